// File: doc/BRIEF.md
# DRAM Bank Access Latency Estimator

This block predicts how many cycles a read or write to one DRAM bank will take, given the state of that bank, for a controller that keeps rows open between accesses. A scheduler presents the row it wants, the current time, and the bank's record: whether a row is open and which one, the time the bank stops being busy, and the earliest time a new activate may be issued. One cycle later the block returns the estimated latency and the kind of access: a row hit, an access to a closed bank, or a row conflict.

On a row hit only the wait for the bank to become free and the column latency count. The minimum active time since the last activate plays no part in a hit. On a miss, the wait for the bank comes first. A precharge is charged only when some other row is actually open, so a bank that an earlier auto-precharge left closed skips it. The activate cannot happen before the bank's activate-allowed time, and any shortfall is added to the latency. The activate-to-column and column latencies come last. The three timing values are elaboration parameters, and all times are unsigned cycle counts that are assumed not to wrap.

Top module: `bank_lat_est`

## Requirements
- R1: `outVld` is 1 in exactly the cycle after a cycle with `inVld` high and 0 otherwise; while reset is held low, `outVld` is 0, `outLatency` is 0 and `outKind` is 0.
- R2: With `bankRowOpen`=1 and `bankOpenRow`==`reqRow`, `outKind` is 0 (hit) and `outLatency` = TCL + max(0, `bankFreeAt` - `arrivalTime`); `bankActAllowedAt` has no effect.
- R3: On a miss, the wait max(0, `bankFreeAt` - `arrivalTime`) is included in the latency, and it is zero when `bankFreeAt` equals `arrivalTime`.
- R4: With `bankRowOpen`=0, `outKind` is 1 (closed) and no precharge term is added: latency = wait + actWait + TRCD + TCL.
- R5: With `bankRowOpen`=1 and a different open row, `outKind` is 2 (conflict) and latency = wait + actWait + TRP + TRCD + TCL.
- R6: The candidate activate time is `arrivalTime` + wait + precharge term (TRP on a conflict, 0 on a closed bank); actWait = `bankActAllowedAt` - candidate when the allowed time is later, else 0.
- R7: In a cycle after one with `inVld` low, `outLatency` and `outKind` keep their previous values.
- R8: With `bankRowOpen`=0, the value of `bankOpenRow` has no effect, even when it equals `reqRow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inVld | input | 1 | Request valid |
| reqRow | input | ROW_W | Requested row |
| arrivalTime | input | TIME_W | Request arrival time |
| bankRowOpen | input | 1 | Bank has a row open |
| bankOpenRow | input | ROW_W | Row currently open in the bank |
| bankFreeAt | input | TIME_W | Time the bank becomes free |
| bankActAllowedAt | input | TIME_W | Earliest time an activate is allowed |
| outVld | output | 1 | Estimate valid |
| outLatency | output | TIME_W+2 | Estimated access latency in cycles |
| outKind | output | 2 | 0 hit, 1 closed bank, 2 row conflict |

## Verification
On every cycle the assertions check the one-cycle valid timing, the hold of the result between requests, the exact latency of a hit that does not wait for the bank, and the lower bounds of the closed-bank and conflict cases. Only the bench's scenarios can show the exact latency when waits for the free time and the activate-allowed time add together. They also show that the activate-allowed time is ignored on a hit, that the open-row value is ignored on a closed bank, and the boundaries where the allowed time equals or just exceeds the candidate activate time.

// File: rtl/bank_lat_pkg.sv
package bank_lat_pkg;

  typedef enum logic [1:0] {
    KIND_HIT      = 2'd0,
    KIND_CLOSED   = 2'd1,
    KIND_CONFLICT = 2'd2
  } accKind_e;

  typedef struct packed {
    logic capture;
    logic clear;
  } ctrlStrobes_t;

endpackage

// File: rtl/bank_lat_ctrl.sv
module bank_lat_ctrl
  import bank_lat_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inVld,
  output ctrlStrobes_t strobes,
  output logic         outVld
);

  logic vldQ;

  always_ff @(posedge clk) begin
    if (!rstN) vldQ <= 1'b0;
    else       vldQ <= inVld;
  end

  always_comb begin
    strobes.capture = rstN && inVld;
    strobes.clear   = !rstN;
  end

  assign outVld = vldQ;

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    inVld |=> outVld);
  assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rstN)
    !inVld |=> !outVld);

endmodule

// File: rtl/bank_lat_calc.sv
module bank_lat_calc
  import bank_lat_pkg::*;
#(
  parameter int unsigned TIME_W = 32,
  parameter int unsigned ROW_W  = 16,
  parameter int unsigned TRP    = 7,
  parameter int unsigned TRCD   = 9,
  parameter int unsigned TCL    = 5,
  localparam int unsigned LAT_W = TIME_W + 2
) (
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [TIME_W-1:0] arrivalTime,
  input  logic              bankRowOpen,
  input  logic [ROW_W-1:0]  bankOpenRow,
  input  logic [TIME_W-1:0] bankFreeAt,
  input  logic [TIME_W-1:0] bankActAllowedAt,
  output logic [LAT_W-1:0]  latency,
  output accKind_e          kind
);

  localparam logic [LAT_W-1:0] PRE_LAT = LAT_W'(TRP);
  localparam logic [LAT_W-1:0] ACT_LAT = LAT_W'(TRCD);
  localparam logic [LAT_W-1:0] COL_LAT = LAT_W'(TCL);

  logic             rowHit;
  logic [LAT_W-1:0] arrX, freeX, actX;
  logic [LAT_W-1:0] freeWait, preDelay, candAct, actWait;

  always_comb begin
    arrX  = LAT_W'(arrivalTime);
    freeX = LAT_W'(bankFreeAt);
    actX  = LAT_W'(bankActAllowedAt);

    rowHit   = bankRowOpen && (bankOpenRow == reqRow);
    freeWait = (freeX > arrX) ? (freeX - arrX) : '0;
    preDelay = bankRowOpen ? PRE_LAT : '0;
    candAct  = arrX + freeWait + preDelay;
    actWait  = (actX > candAct) ? (actX - candAct) : '0;

    if (rowHit) begin
      kind    = KIND_HIT;
      latency = freeWait + COL_LAT;
    end else begin
      kind    = bankRowOpen ? KIND_CONFLICT : KIND_CLOSED;
      latency = freeWait + actWait + preDelay + ACT_LAT + COL_LAT;
    end
  end

endmodule

// File: rtl/bank_lat_dp.sv
module bank_lat_dp
  import bank_lat_pkg::*;
#(
  parameter int unsigned TIME_W = 32,
  parameter int unsigned ROW_W  = 16,
  parameter int unsigned TRP    = 7,
  parameter int unsigned TRCD   = 9,
  parameter int unsigned TCL    = 5,
  localparam int unsigned LAT_W = TIME_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [TIME_W-1:0] arrivalTime,
  input  logic              bankRowOpen,
  input  logic [ROW_W-1:0]  bankOpenRow,
  input  logic [TIME_W-1:0] bankFreeAt,
  input  logic [TIME_W-1:0] bankActAllowedAt,
  output logic [LAT_W-1:0]  outLatency,
  output accKind_e          outKind
);

  logic [LAT_W-1:0] calcLat;
  accKind_e         calcKind;

  bank_lat_calc #(
    .TIME_W(TIME_W), .ROW_W(ROW_W), .TRP(TRP), .TRCD(TRCD), .TCL(TCL)
  ) u_calc (
    .reqRow          (reqRow),
    .arrivalTime     (arrivalTime),
    .bankRowOpen     (bankRowOpen),
    .bankOpenRow     (bankOpenRow),
    .bankFreeAt      (bankFreeAt),
    .bankActAllowedAt(bankActAllowedAt),
    .latency         (calcLat),
    .kind            (calcKind)
  );

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      outLatency <= '0;
      outKind    <= KIND_HIT;
    end else if (strobes.capture) begin
      outLatency <= calcLat;
      outKind    <= calcKind;
    end
  end

  assert_hit_exact_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && bankRowOpen && bankOpenRow == reqRow && bankFreeAt <= arrivalTime)
      |=> (outKind == KIND_HIT && outLatency == LAT_W'(TCL)));
  assert_closed_floor_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !bankRowOpen)
      |=> (outKind == KIND_CLOSED && outLatency >= LAT_W'(TRCD + TCL)));
  assert_conflict_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && bankRowOpen && bankOpenRow != reqRow)
      |=> (outKind == KIND_CONFLICT && outLatency >= LAT_W'(TRP + TRCD + TCL)));

endmodule

// File: rtl/bank_lat_est.sv
module bank_lat_est
  import bank_lat_pkg::*;
#(
  parameter int unsigned TIME_W = 32,
  parameter int unsigned ROW_W  = 16,
  parameter int unsigned TRP    = 7,
  parameter int unsigned TRCD   = 9,
  parameter int unsigned TCL    = 5,
  localparam int unsigned LAT_W = TIME_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inVld,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [TIME_W-1:0] arrivalTime,
  input  logic              bankRowOpen,
  input  logic [ROW_W-1:0]  bankOpenRow,
  input  logic [TIME_W-1:0] bankFreeAt,
  input  logic [TIME_W-1:0] bankActAllowedAt,
  output logic              outVld,
  output logic [LAT_W-1:0]  outLatency,
  output logic [1:0]        outKind
);

  ctrlStrobes_t strobes;
  accKind_e     kindQ;

  bank_lat_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inVld  (inVld),
    .strobes(strobes),
    .outVld (outVld)
  );

  bank_lat_dp #(
    .TIME_W(TIME_W), .ROW_W(ROW_W), .TRP(TRP), .TRCD(TRCD), .TCL(TCL)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobes         (strobes),
    .reqRow          (reqRow),
    .arrivalTime     (arrivalTime),
    .bankRowOpen     (bankRowOpen),
    .bankOpenRow     (bankOpenRow),
    .bankFreeAt      (bankFreeAt),
    .bankActAllowedAt(bankActAllowedAt),
    .outLatency      (outLatency),
    .outKind         (kindQ)
  );

  assign outKind = kindQ;

  assert_hold_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    !inVld |=> ($stable(outLatency) && $stable(outKind)));

endmodule

// File: tb/sim_bank_lat_est.sv
module sim_bank_lat_est;

  localparam int unsigned TIME_W = 32;
  localparam int unsigned ROW_W  = 16;
  localparam int unsigned TRP    = 7;
  localparam int unsigned TRCD   = 9;
  localparam int unsigned TCL    = 5;
  localparam int unsigned LAT_W  = TIME_W + 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inVld = 1'b0;
  logic [ROW_W-1:0]  reqRow = '0;
  logic [TIME_W-1:0] arrivalTime = '0;
  logic              bankRowOpen = 1'b0;
  logic [ROW_W-1:0]  bankOpenRow = '0;
  logic [TIME_W-1:0] bankFreeAt = '0;
  logic [TIME_W-1:0] bankActAllowedAt = '0;
  logic              outVld;
  logic [LAT_W-1:0]  outLatency;
  logic [1:0]        outKind;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bank_lat_est #(.TIME_W(TIME_W), .ROW_W(ROW_W), .TRP(TRP), .TRCD(TRCD), .TCL(TCL)) u0 (
    .clk(clk), .rstN(rstN), .inVld(inVld), .reqRow(reqRow), .arrivalTime(arrivalTime),
    .bankRowOpen(bankRowOpen), .bankOpenRow(bankOpenRow), .bankFreeAt(bankFreeAt),
    .bankActAllowedAt(bankActAllowedAt), .outVld(outVld), .outLatency(outLatency),
    .outKind(outKind)
  );

  function automatic longint expLat(longint arr, bit open, int oRow, int rRow,
                                    longint freeT, longint actT);
    longint w, pre, cand, aw;
    w = (freeT > arr) ? freeT - arr : 0;
    if (open && oRow == rRow) return w + TCL;
    pre  = open ? TRP : 0;
    cand = arr + w + pre;
    aw   = (actT > cand) ? actT - cand : 0;
    return w + aw + pre + TRCD + TCL;
  endfunction

  function automatic int expKind(bit open, int oRow, int rRow);
    if (!open) return 1;
    return (oRow == rRow) ? 0 : 2;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(string req, longint arr, bit open, int oRow, int rRow,
                     longint freeT, longint actT);
    longint lat;
    @(negedge clk);
    inVld = 1'b1; arrivalTime = TIME_W'(arr); bankRowOpen = open;
    bankOpenRow = ROW_W'(oRow); reqRow = ROW_W'(rRow);
    bankFreeAt = TIME_W'(freeT); bankActAllowedAt = TIME_W'(actT);
    @(negedge clk);
    inVld = 1'b0;
    check({req, " valid"}, longint'(outVld), 1);
    check({req, " latency"}, longint'(outLatency), expLat(arr, open, oRow, rRow, freeT, actT));
    check({req, " kind"}, longint'(outKind), expKind(open, oRow, rRow));
    lat = longint'(outLatency);
    // R7 / R1: idle cycle holds result, valid drops
    bankFreeAt = TIME_W'(freeT + 500);
    @(negedge clk);
    check("R1 valid low after idle", longint'(outVld), 0);
    check("R7 latency held", longint'(outLatency), lat);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", longint'(outVld), 0);
    check("R1 reset latency", longint'(outLatency), 0);
    check("R1 reset kind", longint'(outKind), 0);
    rstN = 1'b1;

    // R2: hit, no wait; then waiting for free; actAllowed far away ignored
    run("R2 hit plain", 100, 1, 3, 3, 50, 0);
    run("R2 hit free wait", 100, 1, 3, 3, 130, 0);
    run("R2 hit act ignored", 100, 1, 3, 3, 100, 9000);
    // R3: miss with free wait, and boundary free==arrival
    run("R3 conflict free wait", 200, 1, 4, 5, 260, 0);
    run("R3 closed free equal", 200, 0, 0, 5, 200, 0);
    // R4 / R8: closed bank, open row value equal to request ignored
    run("R4 closed plain", 300, 0, 7, 9, 10, 10);
    run("R8 closed same row value", 300, 0, 9, 9, 10, 10);
    // R5: conflict
    run("R5 conflict plain", 400, 1, 1, 2, 0, 0);
    // R6: clamp boundaries (conflict cand = 400+0+7 = 407)
    run("R6 act equals cand", 400, 1, 1, 2, 0, 407);
    run("R6 act cand plus one", 400, 1, 1, 2, 0, 408);
    run("R6 closed clamp", 500, 0, 1, 2, 520, 600);
    run("R6 conflict both waits", 500, 1, 1, 2, 520, 600);

    begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 300; i++) begin
        longint arr, ft, at;
        bit op;
        int orow, rrow;
        arr  = longint'($urandom_range(0, 5000));
        ft   = arr + longint'($urandom_range(0, 60)) - 30;
        if (ft < 0) ft = 0;
        at   = arr + longint'($urandom_range(0, 80)) - 20;
        if (at < 0) at = 0;
        op   = 1'($urandom_range(0, 1));
        rrow = int'($urandom_range(0, 3));
        orow = ($urandom_range(0, 1) == 1) ? rrow : int'($urandom_range(0, 3));
        run(op ? ((orow == rrow) ? "R2 rand hit" : "R5 rand conflict") : "R4 rand closed",
            arr, op, orow, rrow, ft, at);
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule